// File: doc/BRIEF.md
# Jump Target Resolver

The block settles where a small coprocessor fetches next once a control-transfer instruction reaches it. Each cycle that `in_valid` is high, it decodes the 32-bit instruction word. It uses the current word-addressed program counter, the register bank, and the two flags kept from the last ALU operation. One cycle later it presents the resulting program counter together with a flag that says whether the jump was taken.

There are two kinds of jump. The absolute kind lands on an 11-bit word address. That address comes either from an immediate field or from the low bits of a named register. The jump can fire always, only on a zero result, or only on an overflow. The relative kind moves the counter by up to 127 words in either direction. Its offset is given as a magnitude plus a sign bit. It fires when register 0, compared unsigned, is below a 16-bit immediate, or when it is at or above that immediate. An instruction that is not a jump, or a jump that does not fire, moves the counter one word ahead. Instruction fetch and ALU work are handled elsewhere.

Top module: `jump_resolver`

## Requirements
- R1: A result appears with `out_valid` high exactly one clock after each cycle with `in_valid` high. `out_valid` is low in every other cycle.
- R2: While `rst` is high, and after it is released until the first request, `out_valid`, `taken` and `next_pc` are all zero.
- R3: An instruction whose bits [31:28] are not 8 is not taken. The same holds for a word with bits [31:28] equal to 8 and a sub-code in bits [27:25] other than 0 (absolute) or 1 (relative).
- R4: For an absolute jump with bit 21 at 0, a taken result has `next_pc` equal to bits [12:2] of the instruction.
- R5: For an absolute jump with bit 21 at 1, a taken result has `next_pc` equal to the low 11 bits of the register whose index is in bits [1:0].
- R6: For an absolute jump, condition bits [24:22] decide whether it is taken. Code 0 is always taken. Code 1 is taken when `flag_zero` is high. Code 2 is taken when `flag_ovf` is high. Codes 3 to 7 are never taken.
- R7: For a relative jump, bit 16 at 0 takes the jump when register 0 is below the immediate in bits [15:0]. Bit 16 at 1 takes it when register 0 is at or above that immediate. Both comparisons are unsigned.
- R8: A taken relative jump sets `next_pc` to the current PC plus the magnitude in bits [23:17] when bit 24 is 0, or minus it when bit 24 is 1. The result wraps modulo 2048.
- R9: Every result that is not taken has `next_pc` equal to the current PC plus one, modulo 2048, so 2047 is followed by 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A request is present this cycle |
| insn | input | 32 | Instruction word |
| cur_pc | input | 11 | Word address of this instruction |
| reg_bank | input | 64 | Register bank, register n in bits [16n+15:16n] |
| flag_zero | input | 1 | Last ALU result was zero |
| flag_ovf | input | 1 | Last ALU operation overflowed |
| out_valid | output | 1 | Result valid |
| taken | output | 1 | The jump was taken |
| next_pc | output | 11 | Word address to fetch next |

## Verification
The absolute form is run with each condition code against every combination of the two flags. This separates the zero test from the overflow test, and shows that the unused codes never fire. Register and immediate targets are used with a register value whose upper bits are set, which exposes any failure to truncate the value. Relative jumps are tried with register 0 one below the immediate, equal to it, and at 0xFFFF. This separates less-than from at-or-above, strict from non-strict comparison, and unsigned from signed comparison. Offsets of +127 and -127, plus a forward step past 2047 and a fall-through at 2047, show that both adders wrap modulo 2048.

// File: rtl/jr_pkg.sv
package jr_pkg;
  localparam int INSN_W = 32;
  localparam logic [3:0] OP_JUMP = 4'd8;
  localparam logic [2:0] SUB_ABS = 3'd0;
  localparam logic [2:0] SUB_REL = 3'd1;
  localparam logic [2:0] CC_ALWAYS = 3'd0;
  localparam logic [2:0] CC_ZERO   = 3'd1;
  localparam logic [2:0] CC_OVF    = 3'd2;
  localparam int ABS_ADDR_W = 11;
  localparam int REL_MAG_W  = 7;
  localparam int REL_IMM_W  = 16;
  localparam int RSEL_W     = 2;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_ABS  = 2'd1,
    KIND_REL  = 2'd2
  } jump_kind_e;
endpackage

// File: rtl/jr_abs_target.sv
module jr_abs_target #(
  parameter int PC_W     = 11,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4
) (
  input  logic [jr_pkg::INSN_W-1:0]   insn,
  input  logic [NUM_REGS*DATA_W-1:0]  reg_bank,
  output logic [PC_W-1:0]             target
);
  import jr_pkg::*;
  localparam int SEL_W = RSEL_W;

  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [SEL_W-1:0]  rsel;
  logic [DATA_W-1:0] rval;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_unpack
    assign regs[g] = reg_bank[g*DATA_W +: DATA_W];
  end

  assign rsel = insn[SEL_W-1:0];

  always_comb begin
    rval = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rsel == SEL_W'(i)) rval = regs[i];
    end
  end

  assign target = insn[21] ? PC_W'(rval) : PC_W'(insn[ABS_ADDR_W+1:2]);
endmodule

// File: rtl/jr_rel_target.sv
module jr_rel_target #(
  parameter int PC_W = 11
) (
  input  logic [jr_pkg::INSN_W-1:0] insn,
  input  logic [PC_W-1:0]           cur_pc,
  output logic [PC_W-1:0]           target
);
  import jr_pkg::*;
  logic [PC_W-1:0] mag;

  assign mag    = PC_W'(insn[17 +: REL_MAG_W]);
  assign target = insn[24] ? (cur_pc - mag) : (cur_pc + mag);
endmodule

// File: rtl/jr_cond_eval.sv
module jr_cond_eval #(
  parameter int DATA_W = 16
) (
  input  logic [jr_pkg::INSN_W-1:0] insn,
  input  logic [DATA_W-1:0]         reg0,
  input  logic                      flag_zero,
  input  logic                      flag_ovf,
  output logic                      abs_fire,
  output logic                      rel_fire
);
  import jr_pkg::*;
  logic [2:0]  cc;
  logic [31:0] lhs, rhs;
  logic        below;

  assign cc = insn[24:22];

  always_comb begin
    unique case (cc)
      CC_ALWAYS: abs_fire = 1'b1;
      CC_ZERO:   abs_fire = flag_zero;
      CC_OVF:    abs_fire = flag_ovf;
      default:   abs_fire = 1'b0;
    endcase
  end

  assign lhs      = 32'(reg0);
  assign rhs      = 32'(insn[REL_IMM_W-1:0]);
  assign below    = lhs < rhs;
  assign rel_fire = insn[16] ? !below : below;
endmodule

// File: rtl/jump_resolver.sv
module jump_resolver #(
  parameter int PC_W     = 11,
  parameter int DATA_W   = 16,
  parameter int NUM_REGS = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [31:0]                insn,
  input  logic [PC_W-1:0]            cur_pc,
  input  logic [NUM_REGS*DATA_W-1:0] reg_bank,
  input  logic                       flag_zero,
  input  logic                       flag_ovf,
  output logic                       out_valid,
  output logic                       taken,
  output logic [PC_W-1:0]            next_pc
);
  import jr_pkg::*;

  jump_kind_e       kind;
  logic [PC_W-1:0]  abs_tgt, rel_tgt, seq_pc;
  logic             abs_fire, rel_fire, fire;
  logic [PC_W-1:0]  pick;

  always_comb begin
    kind = KIND_NONE;
    if (insn[31:28] == OP_JUMP) begin
      if (insn[27:25] == SUB_ABS)      kind = KIND_ABS;
      else if (insn[27:25] == SUB_REL) kind = KIND_REL;
    end
  end

  jr_abs_target #(.PC_W(PC_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_abs (
    .insn(insn), .reg_bank(reg_bank), .target(abs_tgt));

  jr_rel_target #(.PC_W(PC_W)) u_rel (
    .insn(insn), .cur_pc(cur_pc), .target(rel_tgt));

  jr_cond_eval #(.DATA_W(DATA_W)) u_cond (
    .insn(insn), .reg0(reg_bank[DATA_W-1:0]), .flag_zero(flag_zero),
    .flag_ovf(flag_ovf), .abs_fire(abs_fire), .rel_fire(rel_fire));

  assign seq_pc = cur_pc + PC_W'(1);

  always_comb begin
    unique case (kind)
      KIND_ABS: begin fire = abs_fire; pick = abs_tgt; end
      KIND_REL: begin fire = rel_fire; pick = rel_tgt; end
      default:  begin fire = 1'b0;     pick = seq_pc;  end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      taken     <= 1'b0;
      next_pc   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        taken   <= fire;
        next_pc <= fire ? pick : seq_pc;
      end
    end
  end

  AST_RESULT_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R1
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R1
  AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken) |-> next_pc == PC_W'($past(cur_pc) + PC_W'(1))); // R9
  AST_NONJUMP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(insn[31:28]) != OP_JUMP) |-> !taken); // R3
  AST_ABS_UNCOND: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(kind == KIND_ABS && insn[24:22] == CC_ALWAYS)) |-> taken); // R6
  AST_ABS_IMM_DEST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && taken && $past(kind == KIND_ABS && !insn[21]))
      |-> next_pc == PC_W'($past(insn[12:2]))); // R4
  AST_REL_FWD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && taken && $past(kind == KIND_REL && !insn[24]))
      |-> next_pc == PC_W'($past(cur_pc) + PC_W'($past(insn[23:17])))); // R8
endmodule

// File: tb/jump_resolver_tb.sv
module jump_resolver_tb;
  localparam int PC_W = 11;
  localparam int DW   = 16;
  localparam int NR   = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [31:0] insn = '0;
  logic [PC_W-1:0] cur_pc = '0;
  logic [NR*DW-1:0] reg_bank = '0;
  logic flag_zero = 1'b0, flag_ovf = 1'b0;
  logic out_valid, taken;
  logic [PC_W-1:0] next_pc;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  logic [PC_W-1:0] q_pc [$];
  logic            q_tk [$];
  int              q_cy [$];
  string           q_tag [$];

  jump_resolver #(.PC_W(PC_W), .DATA_W(DW), .NUM_REGS(NR)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .insn(insn), .cur_pc(cur_pc),
    .reg_bank(reg_bank), .flag_zero(flag_zero), .flag_ovf(flag_ovf),
    .out_valid(out_valid), .taken(taken), .next_pc(next_pc));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mk_abs(input logic [2:0] cc, input logic useReg,
                                         input logic [1:0] rs, input logic [10:0] a);
    return {4'd8, 3'd0, cc, useReg, 8'd0, a, rs};
  endfunction

  function automatic logic [31:0] mk_rel(input logic neg, input logic [6:0] m,
                                         input logic ge, input logic [15:0] imm);
    return {4'd8, 3'd1, neg, m, ge, imm};
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: computes the expectation from the requirements and queues it.
  task automatic send(input string tag, input logic [31:0] w, input logic [10:0] pc,
                      input logic [NR*DW-1:0] rb, input logic z, input logic o);
    logic tk;
    logic [10:0] dest;
    logic [15:0] r0;
    @(posedge clk); #2;
    in_valid = 1'b1; insn = w; cur_pc = pc; reg_bank = rb; flag_zero = z; flag_ovf = o;
    tk = 1'b0; dest = pc + 11'd1;
    r0 = rb[15:0];
    if (w[31:28] == 4'd8 && w[27:25] == 3'd0) begin
      tk = (w[24:22] == 3'd0) || (w[24:22] == 3'd1 && z) || (w[24:22] == 3'd2 && o);
      if (tk) dest = w[21] ? rb[w[1:0]*16 +: 11] : w[12:2];
    end else if (w[31:28] == 4'd8 && w[27:25] == 3'd1) begin
      tk = w[16] ? (r0 >= w[15:0]) : (r0 < w[15:0]);
      if (tk) dest = w[24] ? pc - 11'(w[23:17]) : pc + 11'(w[23:17]);
    end
    q_pc.push_back(dest); q_tk.push_back(tk); q_cy.push_back(cyc); q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2; in_valid = 1'b0;
    end
  endtask

  // Monitor: compares results as they come out
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (q_pc.size() == 0) begin
          checks++; errors++;
          $display("FAIL R1 unexpected result: actual out_valid 1 expected 0");
        end else begin
          string tg;
          int c0;
          logic [10:0] ep;
          logic et;
          tg = q_tag.pop_front(); ep = q_pc.pop_front(); et = q_tk.pop_front(); c0 = q_cy.pop_front();
          check("R1", "latency", cyc - c0, 1);
          check(tg, "taken", int'(taken), int'(et));
          check(tg, "next_pc", int'(next_pc), int'(ep));
        end
      end else if (q_pc.size() != 0 && q_cy[0] < cyc - 1) begin
        checks++; errors++;
        $display("FAIL R1 missing result: actual out_valid 0 expected 1");
        void'(q_pc.pop_front()); void'(q_tk.pop_front());
        void'(q_cy.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R2", "out_valid in reset", int'(out_valid), 0);
    check("R2", "taken in reset", int'(taken), 0);
    check("R2", "next_pc in reset", int'(next_pc), 0);
    @(posedge clk); #2; rst = 1'b0;
    @(negedge clk);
    check("R2", "out_valid after release", int'(out_valid), 0);

    // R3: not a jump, and a jump word with an unknown sub-code
    send("R3", 32'h7000_0003, 11'd40, '0, 1'b1, 1'b1);
    send("R3", {4'd8, 3'd2, 25'h1FF_FFFF}, 11'd41, '0, 1'b1, 1'b1);
    // R4: immediate target
    send("R4", mk_abs(3'd0, 1'b0, 2'd3, 11'h5A3), 11'd7, '0, 1'b0, 1'b0);
    // R5: register target, upper bits set
    send("R5", mk_abs(3'd0, 1'b1, 2'd2, 11'h000), 11'd7, {16'h0, 16'hF123, 16'h0, 16'h0}, 1'b0, 1'b0);
    send("R5", mk_abs(3'd0, 1'b1, 2'd3, 11'h000), 11'd7, {16'hFFFF, 16'h0, 16'h0, 16'h0}, 1'b0, 1'b0);
    // R6: all condition codes against all flag combinations
    for (int c = 0; c < 8; c++)
      for (int f = 0; f < 4; f++)
        send("R6", mk_abs(3'(c), 1'b0, 2'd0, 11'd300), 11'd20, '0, f[0], f[1]);
    idle(3);
    // R7: unsigned compare against the immediate
    send("R7", mk_rel(1'b0, 7'd3, 1'b0, 16'd6), 11'd50, 64'd5, 1'b0, 1'b0);
    send("R7", mk_rel(1'b0, 7'd3, 1'b0, 16'd6), 11'd50, 64'd6, 1'b0, 1'b0);
    send("R7", mk_rel(1'b0, 7'd3, 1'b1, 16'd6), 11'd50, 64'd6, 1'b0, 1'b0);
    send("R7", mk_rel(1'b0, 7'd3, 1'b1, 16'd6), 11'd50, 64'd5, 1'b0, 1'b0);
    send("R7", mk_rel(1'b0, 7'd3, 1'b1, 16'd1), 11'd50, 64'hFFFF, 1'b0, 1'b0);
    send("R7", mk_rel(1'b0, 7'd3, 1'b0, 16'd1), 11'd50, 64'hFFFF, 1'b0, 1'b0);
    // R8: extreme offsets and wrap both ways
    send("R8", mk_rel(1'b0, 7'd127, 1'b1, 16'd0), 11'd100, '0, 1'b0, 1'b0);
    send("R8", mk_rel(1'b1, 7'd127, 1'b1, 16'd0), 11'd10, '0, 1'b0, 1'b0);
    send("R8", mk_rel(1'b0, 7'd5, 1'b1, 16'd0), 11'd2045, '0, 1'b0, 1'b0);
    send("R8", mk_rel(1'b1, 7'd0, 1'b1, 16'd0), 11'd33, '0, 1'b0, 1'b0);
    // R9: fall-through wraps at the top of the space
    send("R9", mk_abs(3'd1, 1'b0, 2'd0, 11'd5), 11'd2047, '0, 1'b0, 1'b1);
    send("R9", mk_rel(1'b0, 7'd9, 1'b0, 16'd0), 11'd2047, 64'd4, 1'b0, 1'b0);
    idle(4);
    if (q_pc.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 results outstanding: actual %0d expected 0", q_pc.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule